// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a cycle-accurate model of a flow-through synchronous static RAM with a built-in 2-bit burst sequencer. Every control and address input is captured on the rising clock edge. Each captured cycle is resolved into one of four operations: deselect, start of a new burst, advance of the running burst, or suspension of the burst. A burst can be opened by either of two active-low start strobes. One is meant for a processor and the other for a cache controller, and the two differ in how the chip selects mask them and in whether the opening cycle may write.

During a burst, the upper address bits stay frozen at the values captured at the start. The low two bits come from a counter that runs in linear or interleaved order. Reads are flow-through: the word addressed by the registered state appears on the data output in the same cycle, gated by an asynchronous output enable. Writes can cover every byte lane at once or chosen lanes only. A sleep input shuts the device down after a fixed two-edge latency and wakes it up with the same latency.

The storage depth and the number of byte lanes are parameters. The data bus is split into an input, an output and an output-driver enable, which a pad ring combines into a tri-state pin.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle opened by `start_cpu_n` low with `sel_n` low is always a read, whatever `wr_all_n`, `byte_wr_en_n` and `byte_wr_n` carry.
- R2: When `sel_n` is high, `start_cpu_n` low has no effect. If `start_ctl_n` is also high, the cycle is a continue cycle when `step_n` is low and a suspend cycle when `step_n` is high. The device is not deselected and no new burst starts.
- R3: A start cycle (opened by either strobe) in which `sel_n` is high, `sel_hi` is low or `sel2_n` is high deselects the device. `data_oe` stays low until a later start cycle succeeds, including during continue and suspend cycles.
- R4: `sel_hi` and `sel2_n` are examined only in start cycles. Continue and suspend cycles behave the same whatever their values.
- R5: `wr_all_n` low writes all byte lanes, in a start cycle opened by `start_ctl_n` or in any continue or suspend cycle of an active burst.
- R6: When `wr_all_n` is high, `byte_wr_en_n` low together with `byte_wr_n[i]` low writes lane i, which is bits 8i+7..8i. `byte_wr_en_n` high, or all `byte_wr_n` bits high, makes the cycle a read.
- R7: The burst count is 0 in the start cycle and rises by one in each continue cycle, modulo 4. `order_ilv` is latched at the start. With `order_ilv` = 1, the low address bits are the start low bits XOR the count. With `order_ilv` = 0, they are the start low bits plus the count, modulo 4.
- R8: In a suspend cycle (`step_n` high, no start), the burst address does not change.
- R9: After the edge that registers a read, `data_out` carries the word at the burst address in that same cycle, with `data_oe` high, as long as `out_en_n` is low. `out_en_n` high forces `data_oe` low. Whenever `data_oe` is low, `data_out` is zero.
- R10: During a registered write cycle, `data_oe` is low whatever `out_en_n` is. `wdata` is captured on the edge that registers the write, and the word is updated in time for a read of the following cycle.
- R11: At the first two rising edges with `sleep` high, inputs are still acted on. From the third such edge, inputs are ignored and `data_oe` is low. After `sleep` falls, the first two edges still ignore inputs, and inputs are acted on again from the third edge.
- R12: Bits above the low two of `addr` are latched at a burst start and are unaffected by `addr` during continue and suspend cycles.
- R13: While `rst_n` is low and after it is released, `data_oe` is low and no burst is active until the first successful start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, sampled in start cycles |
| start_cpu_n | input | 1 | Processor burst-start strobe, active low |
| start_ctl_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance when low, suspend when high |
| wr_all_n | input | 1 | Write every byte lane, active low |
| byte_wr_en_n | input | 1 | Enables the per-lane write strobes, active low |
| byte_wr_n | input | LANES | Per-lane write strobes, active low |
| sel_n | input | 1 | Primary chip select, active low; gates the processor strobe |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel2_n | input | 1 | Secondary chip select, active low |
| order_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power sleep request, active high |
| wdata | input | LANES*8 | Write data |
| data_out | output | LANES*8 | Read data, zero when not driven |
| data_oe | output | 1 | Output driver enable for the data pins |

## Verification
The embedded properties check the cycle-level rules on every clock. They confirm that a processor-opened cycle never registers a write, that a blocked processor strobe leaves the row and the selection state untouched, that a failed start turns the outputs off, that suspend cycles hold the address, and that the driver stays off during writes and while asleep. Some behaviour cannot be captured by a local property, and only the bench scenarios compare it against the reference array. This covers the actual word contents after global and partial writes, the linear and interleaved address sequences, the exact two-edge entry and exit of sleep with a write that must be dropped, and the indifference of continue cycles to the secondary selects.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   localparam int LANE_W = 8;
   localparam int CNT_W  = 2;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_t;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
   import bsram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             asleep,
   input  logic             act,
   input  logic             start_cpu_n,
   input  logic             start_ctl_n,
   input  logic             step_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             sel2_n,
   input  logic             wr_all_n,
   input  logic             byte_wr_en_n,
   input  logic [LANES-1:0] byte_wr_n,
   output logic             load,
   output logic             adv,
   output logic             desel,
   output cyc_t             cyc,
   output logic [LANES-1:0] mask
);
   logic cpu_go, ctl_go, sel_ok, any_wr;

   always_comb begin
      // the processor strobe only counts when the primary select is active
      cpu_go = !start_cpu_n && !sel_n;
      ctl_go = !start_ctl_n && !cpu_go;
      sel_ok = !sel_n && sel_hi && !sel2_n;

      if (!wr_all_n)          mask = '1;
      else if (!byte_wr_en_n) mask = ~byte_wr_n;
      else                    mask = '0;
      any_wr = |mask;

      load  = 1'b0;
      adv   = 1'b0;
      desel = 1'b0;
      cyc   = CYC_IDLE;
      if (!asleep) begin
         if (cpu_go || ctl_go) begin
            if (!sel_ok) begin
               desel = 1'b1;
            end else begin
               load = 1'b1;
               cyc  = (ctl_go && any_wr) ? CYC_WRITE : CYC_READ;
            end
         end else begin
            adv = !step_n;
            if (act) cyc = any_wr ? CYC_WRITE : CYC_READ;
         end
      end
   end
endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
   import bsram_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic          ilv_in,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out
);
   logic [AW-1:CNT_W]  row_q;
   logic [CNT_W-1:0]   base_lo_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               ilv_q;
   logic [CNT_W-1:0]   lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q     <= '0;
         base_lo_q <= '0;
         cnt_q     <= '0;
         ilv_q     <= 1'b0;
      end else if (load) begin
         row_q     <= addr_in[AW-1:CNT_W];
         base_lo_q <= addr_in[CNT_W-1:0];
         cnt_q     <= '0;
         ilv_q     <= ilv_in;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      if (ilv_q) lo = base_lo_q ^ cnt_q;
      else       lo = base_lo_q + cnt_q;
   end

   assign addr_out = {row_q, lo};

   // R7: one continue step moves the count by exactly one
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/bsram_array.sv
module bsram_array
   import bsram_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int LANES = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [LANES-1:0] lane_we,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_we[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[addr];
   end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import bsram_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int LANES = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             start_cpu_n,
   input  logic             start_ctl_n,
   input  logic             step_n,
   input  logic             wr_all_n,
   input  logic             byte_wr_en_n,
   input  logic [LANES-1:0] byte_wr_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             sel2_n,
   input  logic             order_ilv,
   input  logic             out_en_n,
   input  logic             sleep,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    data_out,
   output logic             data_oe
);
   initial begin : g_param_chk
      p_params_ok: assert (DEPTH >= 8 && (DEPTH & (DEPTH - 1)) == 0 && LANES >= 1)
         else $error("depth must be a power of two of at least 8, lanes at least 1");
   end

   // sleep latency: two registers between the pin and the gating
   logic nap_q1, nap_q2;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nap_q1 <= 1'b0;
         nap_q2 <= 1'b0;
      end else begin
         nap_q1 <= sleep;
         nap_q2 <= nap_q1;
      end
   end
   logic asleep;
   assign asleep = nap_q2;

   logic             act_q;
   cyc_t             cyc_q, cyc_n;
   logic [LANES-1:0] mask_q, mask_n;
   logic [DW-1:0]    wdata_q;
   logic             load, adv, desel;
   logic [AW-1:0]    mem_addr;
   logic [DW-1:0]    rdata;

   bsram_decode #(.LANES(LANES)) u_dec (
      .asleep      (asleep),
      .act         (act_q),
      .start_cpu_n (start_cpu_n),
      .start_ctl_n (start_ctl_n),
      .step_n      (step_n),
      .sel_n       (sel_n),
      .sel_hi      (sel_hi),
      .sel2_n      (sel2_n),
      .wr_all_n    (wr_all_n),
      .byte_wr_en_n(byte_wr_en_n),
      .byte_wr_n   (byte_wr_n),
      .load        (load),
      .adv         (adv),
      .desel       (desel),
      .cyc         (cyc_n),
      .mask        (mask_n)
   );

   bsram_burst_seq #(.AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .adv     (adv),
      .ilv_in  (order_ilv),
      .addr_in (addr),
      .addr_out(mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         cyc_q   <= CYC_IDLE;
         mask_q  <= '0;
         wdata_q <= '0;
      end else begin
         if (desel)     act_q <= 1'b0;
         else if (load) act_q <= 1'b1;
         cyc_q   <= cyc_n;
         mask_q  <= mask_n;
         wdata_q <= wdata;
      end
   end

   bsram_array #(.DEPTH(DEPTH), .LANES(LANES)) u_mem (
      .clk    (clk),
      .we     (cyc_q == CYC_WRITE),
      .lane_we(mask_q),
      .addr   (mem_addr),
      .wdata  (wdata_q),
      .rdata  (rdata)
   );

   assign data_oe  = !asleep && act_q && (cyc_q == CYC_READ) && !out_en_n;
   assign data_out = data_oe ? rdata : '0;

   // R1: a processor-opened cycle never registers a write
   p_cpu_start_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && !start_cpu_n && !sel_n) |=> (cyc_q != CYC_WRITE));

   // R2: a blocked processor strobe changes neither row nor selection
   p_blocked_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_cpu_n && sel_n && start_ctl_n)
         |=> ($stable(mem_addr[AW-1:CNT_W]) && (act_q == $past(act_q))));

   // R3: a start with any select inactive leaves the bus undriven
   p_desel_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && ((!start_cpu_n && !sel_n) || !start_ctl_n)
         && (sel_n || !sel_hi || sel2_n)) |=> (!data_oe && !act_q));

   // R8: suspend keeps the whole address
   p_suspend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cpu_n && start_ctl_n && step_n) |=> $stable(mem_addr));

   // R12: no start, no change of the row
   p_row_latched_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cpu_n && start_ctl_n) |=> $stable(mem_addr[AW-1:CNT_W]));

   // R10: driver off in write cycles
   p_write_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CYC_WRITE) |-> !data_oe);

   // R11: driver off while asleep
   p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !data_oe);
endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
   localparam int DEPTH = 256;
   localparam int LANES = 4;
   localparam int AW    = 8;
   localparam int DW    = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    addr;
   logic             start_cpu_n, start_ctl_n, step_n;
   logic             wr_all_n, byte_wr_en_n;
   logic [LANES-1:0] byte_wr_n;
   logic             sel_n, sel_hi, sel2_n;
   logic             order_ilv, out_en_n, sleep;
   logic [DW-1:0]    wdata;
   logic [DW-1:0]    data_out;
   logic             data_oe;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sync_burst_sram #(.DEPTH(DEPTH), .LANES(LANES)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
      .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n), .byte_wr_n(byte_wr_n),
      .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
      .order_ilv(order_ilv), .out_en_n(out_en_n), .sleep(sleep),
      .wdata(wdata), .data_out(data_out), .data_oe(data_oe)
   );

   // behavioural reference state
   logic [DW-1:0] m_mem [DEPTH];
   bit            m_act, m_rd, m_wr, m_ilv, m_q1, m_q2;
   int            m_base, m_cnt;
   logic [3:0]    m_mask;
   logic [DW-1:0] m_wdata;

   function automatic int m_addr();
      int lo;
      if (m_ilv) lo = (m_base % 4) ^ m_cnt;
      else       lo = ((m_base % 4) + m_cnt) % 4;
      return (m_base - (m_base % 4)) + lo;
   endfunction

   function automatic logic [DW-1:0] pattern(int a);
      return (a * 32'h9E3779B1) ^ 32'h1234_5678;
   endfunction

   task automatic model_edge();
      int a;
      bit was_asleep, cpu, ctl;
      logic [3:0] mk;
      a = m_addr();
      if (m_wr)
         for (int b = 0; b < 4; b++)
            if (m_mask[b]) m_mem[a][b*8 +: 8] = m_wdata[b*8 +: 8];
      was_asleep = m_q2;
      m_q2 = m_q1;
      m_q1 = sleep;
      if (was_asleep) begin
         m_rd = 0; m_wr = 0;
      end else begin
         cpu = !start_cpu_n && !sel_n;
         ctl = !start_ctl_n && !cpu;
         if (!wr_all_n)          mk = 4'hF;
         else if (!byte_wr_en_n) mk = ~byte_wr_n;
         else                    mk = 4'h0;
         m_mask = mk;
         m_wdata = wdata;
         if (cpu || ctl) begin
            if (sel_n || !sel_hi || sel2_n) begin
               m_act = 0; m_rd = 0; m_wr = 0;
            end else begin
               m_act = 1; m_base = int'(addr); m_ilv = order_ilv; m_cnt = 0;
               m_wr = ctl && (mk != 0);
               m_rd = !m_wr;
            end
         end else begin
            if (!step_n) m_cnt = (m_cnt + 1) % 4;
            m_wr = m_act && (mk != 0);
            m_rd = m_act && (mk == 0);
         end
      end
   endtask

   task automatic compare(string req);
      bit exp_oe;
      logic [DW-1:0] exp_d;
      exp_oe = !m_q2 && m_rd && !out_en_n;
      exp_d  = exp_oe ? m_mem[m_addr()] : '0;
      n_checks++;
      if (data_oe !== exp_oe || data_out !== exp_d) begin
         n_errors++;
         $display("FAIL %s: data_oe=%0b data_out=%h expected data_oe=%0b data_out=%h",
                  req, data_oe, data_out, exp_oe, exp_d);
      end
   endtask

   task automatic tick(string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(req);
   endtask

   task automatic idle();
      start_cpu_n = 1; start_ctl_n = 1; step_n = 1;
      wr_all_n = 1; byte_wr_en_n = 1; byte_wr_n = 4'hF;
      sel_n = 0; sel_hi = 1; sel2_n = 0;
      out_en_n = 0; sleep = 0;
   endtask

   task automatic burst_read(int a, bit ilv, string req);
      idle(); order_ilv = ilv; start_cpu_n = 0; addr = AW'(a);
      tick(req);
      for (int k = 0; k < 3; k++) begin
         idle(); step_n = 0; addr = AW'(a + 77);
         tick(req);
      end
   endtask

   initial begin
      idle(); order_ilv = 0; addr = '0; wdata = '0;
      m_act = 0; m_rd = 0; m_wr = 0; m_ilv = 0; m_q1 = 0; m_q2 = 0;
      m_base = 0; m_cnt = 0; m_mask = 0; m_wdata = 0;
      repeat (3) @(negedge clk);
      // R13: reset state
      n_checks++;
      if (data_oe !== 1'b0 || data_out !== '0) begin
         n_errors++;
         $display("FAIL R13: data_oe=%0b data_out=%h expected 0 0", data_oe, data_out);
      end
      rst_n = 1;
      tick("R13");

      // R5: fill the array with global-write bursts
      for (int blk = 0; blk < DEPTH / 4; blk++) begin
         idle(); start_ctl_n = 0; addr = AW'(blk * 4); wr_all_n = 0;
         wdata = pattern(blk * 4);
         tick("R5");
         for (int k = 1; k < 4; k++) begin
            idle(); step_n = 0; wr_all_n = 0; byte_wr_en_n = 0; byte_wr_n = 4'hF;
            wdata = pattern(blk * 4 + k);
            tick("R5");
         end
      end

      // R7: linear from low bits 2, interleaved from low bits 1
      burst_read(22, 0, "R7");
      burst_read(45, 1, "R7");
      burst_read(63, 1, "R7");

      // R1: processor start with every write input active still reads
      idle(); start_cpu_n = 0; addr = 8'd30; wr_all_n = 0; byte_wr_en_n = 0;
      byte_wr_n = 4'h0; wdata = 32'hFFFF_FFFF;
      tick("R1");
      idle(); tick("R1");

      // R6: lanes 0 and 2 written, then reads with strobes ineffective
      idle(); start_ctl_n = 0; addr = 8'd60; byte_wr_en_n = 0; byte_wr_n = 4'b1010;
      wdata = 32'hDEAD_BEEF;
      tick("R6");
      idle(); byte_wr_n = 4'h0; tick("R6");
      idle(); byte_wr_en_n = 0; byte_wr_n = 4'hF; tick("R6");
      idle(); step_n = 0; byte_wr_en_n = 0; byte_wr_n = 4'b0111; wdata = 32'h0BAD_F00D;
      tick("R6");
      burst_read(60, 0, "R6");

      // R8 and R12: suspend, then steps with a moving address input
      idle(); start_cpu_n = 0; addr = 8'd70; order_ilv = 0; tick("R8");
      idle(); addr = 8'd200; tick("R8");
      idle(); addr = 8'd201; tick("R8");
      idle(); step_n = 0; addr = 8'd140; tick("R12");
      idle(); step_n = 0; addr = 8'd3; tick("R12");

      // R2: processor strobe blocked by the primary select
      idle(); start_cpu_n = 0; sel_n = 1; step_n = 0; addr = 8'd10; tick("R2");
      idle(); start_cpu_n = 0; sel_n = 1; step_n = 1; addr = 8'd11; tick("R2");

      // R4: secondary selects inactive outside start cycles
      idle(); sel_hi = 0; sel2_n = 1; step_n = 0; tick("R4");
      idle(); sel_hi = 0; sel2_n = 1; tick("R4");

      // R3: failed starts
      idle(); start_ctl_n = 0; addr = 8'd90; sel_hi = 0; tick("R3");
      idle(); step_n = 0; tick("R3");
      idle(); start_cpu_n = 0; addr = 8'd91; tick("R3");
      idle(); start_cpu_n = 0; addr = 8'd92; sel2_n = 1; tick("R3");
      idle(); start_cpu_n = 0; start_ctl_n = 0; sel_n = 1; addr = 8'd93; tick("R3");
      idle(); tick("R3");

      // R9: output enable gating during a read
      idle(); start_cpu_n = 0; addr = 8'd100; out_en_n = 1; tick("R9");
      idle(); tick("R9");
      idle(); step_n = 0; out_en_n = 1; tick("R9");
      idle(); step_n = 0; tick("R9");

      // R10: writes do not drive, and are readable next cycle
      idle(); start_ctl_n = 0; addr = 8'd110; wr_all_n = 0; wdata = 32'hCAFE_0001; tick("R10");
      idle(); step_n = 0; wr_all_n = 0; wdata = 32'hCAFE_0002; tick("R10");
      idle(); tick("R10");
      burst_read(110, 0, "R10");

      // R11: sleep entry and exit latency, with writes that must be dropped
      idle(); start_cpu_n = 0; addr = 8'd120; tick("R11");
      idle(); sleep = 1; tick("R11");
      idle(); sleep = 1; tick("R11");
      idle(); sleep = 1; start_ctl_n = 0; addr = 8'd120; wr_all_n = 0; wdata = '0; tick("R11");
      idle(); sleep = 1; step_n = 0; wr_all_n = 0; wdata = '0; tick("R11");
      idle(); start_ctl_n = 0; addr = 8'd120; wr_all_n = 0; wdata = '0; tick("R11");
      idle(); step_n = 0; wr_all_n = 0; wdata = '0; tick("R11");
      idle(); tick("R11");
      burst_read(120, 0, "R11");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule